// File: doc/BRIEF.md
# LIN Slave Frame Response Controller

This block is the frame-level control core of a LIN slave node. It sits between a byte-level LIN receiver/transmitter (which handles bit timing, break detection, synchronisation and checksums) and a small register window used by firmware. The lower layer reports a decoded identifier, received data bytes, bus activity and error pulses. The block raises one interrupt line and exposes status, control, error, length, identifier and an eight-byte data buffer.

After every identifier the block stalls with a pending request. Firmware reads the identifier and chooses the response direction and length. For a transmit response it also loads the buffer. It then acknowledges. Only after the acknowledge does the block stream bytes out to the transmitter or store incoming bytes at rising buffer addresses.

Deadlines are enforced. A late acknowledge for a transmit response produces silence. A data byte that arrives before the acknowledge overwrites buffer entry 0 and flags a timeout. Buffer and identifier access from firmware is fenced while the bus is busy and while no request or finished frame is pending.

Top module: `lin_slave_frame_ctrl`

## Requirements
- R1: `irq` rises one cycle after an identifier event, a newly flagged error or a completed frame. It stays high until firmware writes control (address 0x9) with bit 3 (interrupt reset) set. That bit is self-clearing and always reads back 0.
- R2: Status (address 0x8) reads bit 0 = frame done, bit 2 = any error, bit 4 = request pending, bit 7 = bus active (mirrors `bus_active`), other bits 0.
- R3: An `id_valid` pulse latches `id_value`, sets the request-pending bit and clears done. The identifier reads at address 0xC, bits 5:0.
- R4: Buffer bytes (addresses 0x0–0x7) and the identifier register are accessible only while the bus is idle and either a request is pending or done is set. Otherwise, writes are ignored and reads return 0.
- R5: Writing control with bit 4 (acknowledge) set while a request is pending clears the request. Bit 5 of the same write selects the direction (1 = slave transmits, 0 = slave receives). Nothing is offered to the transmitter while a request is pending.
- R6: In a transmit response, buffer bytes 0..n-1 are presented on `tx_byte` with `tx_valid`, advancing on each cycle with `tx_ready`. After byte n-1 is accepted, done and the interrupt are set.
- R7: The length register (address 0xB, bits 3:0) gives n. Values 1 to 8 are used as is; 0 or values above 8 mean 8.
- R8: If a transmit acknowledge arrives `RSP_WINDOW` or more cycles after the identifier, no byte is offered. The request clears and done stays 0.
- R9: In a receive response, bytes from `rx_valid` are stored at buffer addresses 0..n-1. After byte n, done and the interrupt are set, and the bytes read back from the buffer.
- R10: A received byte that arrives while a request is still pending is written to buffer entry 0. It sets the timeout error (error register bit 0) and clears the request.
- R11: The error register (address 0xA) has bit 0 = timeout, bit 1 = readback mismatch, bit 2 = framing. A `tx_mismatch` pulse during a transmit response, or a `lin_frame_err` pulse during any response, aborts the frame without setting done. Writing control bit 2 clears all error bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | One-cycle pulse: identifier decoded |
| id_value | input | 6 | Decoded identifier |
| rx_valid | input | 1 | One-cycle pulse: data byte received |
| rx_byte | input | 8 | Received data byte |
| bus_active | input | 1 | Lower layer reports the bus busy |
| lin_frame_err | input | 1 | One-cycle pulse: lower-layer framing error |
| tx_mismatch | input | 1 | One-cycle pulse: transmitted bit read back wrong |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_valid | output | 1 | A response byte is offered |
| tx_byte | output | 8 | Offered response byte |
| reg_addr | input | 4 | Firmware register address |
| reg_wr | input | 1 | Firmware write strobe |
| reg_wdata | input | 8 | Firmware write data |
| reg_rdata | output | 8 | Firmware read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the lower layer's event inputs are single-cycle pulses and that `tx_ready` is only asserted while a byte is offered. The interrupt-cause property also relies on an interrupt rising only after one of those pulses. The stimulus drives every pulse for exactly one clock and raises `tx_ready` only in a cycle where it has just seen `tx_valid` high. Identifier pulses are never overlapped with data bytes, and the bus-active flag changes only between register accesses.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    localparam int BUF_DEPTH = 8;
    localparam int DATA_W    = 8;
    localparam int ID_W      = 6;
    localparam int IDX_W     = $clog2(BUF_DEPTH);
    localparam int LEN_W     = IDX_W + 1;

    // register addresses; 0x0..0x7 are the buffer
    localparam logic [3:0] A_STAT = 4'h8;
    localparam logic [3:0] A_CTRL = 4'h9;
    localparam logic [3:0] A_ERR  = 4'hA;
    localparam logic [3:0] A_LEN  = 4'hB;
    localparam logic [3:0] A_ID   = 4'hC;

    // control bit positions
    localparam int C_DIR  = 5;
    localparam int C_ACK  = 4;
    localparam int C_RINT = 3;
    localparam int C_RERR = 2;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_TX   = 2'd2,
        S_RX   = 2'd3
    } seq_state_e;

    // lsb is timeout, then mismatch, then framing
    typedef struct packed {
        logic framing;
        logic mismatch;
        logic timeout;
    } err_flags_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [3:0] raw);
        if (raw == 4'd0 || int'(raw) > BUF_DEPTH)
            return LEN_W'(BUF_DEPTH);
        return LEN_W'(raw);
    endfunction

endpackage

// File: rtl/lsf_buffer.sv
module lsf_buffer
    import lsf_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int W     = DATA_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_we,
    input  logic [AW-1:0] fw_addr,
    input  logic [W-1:0]  fw_wdata,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [W-1:0]  core_wdata,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (core_we && core_addr == AW'(g))
                mem[g] <= core_wdata;
            else if (fw_we && fw_addr == AW'(g))
                mem[g] <= fw_wdata;
        end
    end

    assign rd_a = mem[rd_addr_a];
    assign rd_b = mem[rd_addr_b];

endmodule

// File: rtl/lsf_window.sv
module lsf_window #(
    parameter int WINDOW = 64,
    localparam int CW    = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CW'(WINDOW);
        else if (restart)
            cnt <= '0;
        else if (cnt != CW'(WINDOW))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(WINDOW));

endmodule

// File: rtl/lsf_seq.sv
module lsf_seq
    import lsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic             rx_valid,
    input  logic             tx_ready,
    input  logic             frame_err,
    input  logic             mismatch,
    input  logic             ack,
    input  logic             dir_tx,
    input  logic             expired,
    input  logic [LEN_W-1:0] len_eff,
    input  logic             rst_int,
    input  logic             rst_err,
    output logic [IDX_W-1:0] idx,
    output logic             dtreq,
    output logic             done,
    output logic             irq,
    output err_flags_t       err,
    output logic             core_we,
    output logic [IDX_W-1:0] core_addr,
    output logic             tx_valid
);

    seq_state_e state;
    err_flags_t err_set;
    logic       last, in_xfer, abort, timeout_hit, fin, irq_set;

    always_comb begin
        last        = ({1'b0, idx} == len_eff - 1'b1);
        in_xfer     = (state == S_TX) || (state == S_RX);
        tx_valid    = (state == S_TX);
        timeout_hit = (state == S_WAIT) && rx_valid && !id_valid;
        core_we     = rx_valid && !id_valid && ((state == S_WAIT) || (state == S_RX));
        core_addr   = (state == S_RX) ? idx : '0;
        err_set.timeout  = timeout_hit;
        err_set.mismatch = mismatch && (state == S_TX);
        err_set.framing  = frame_err;
        abort       = (frame_err && in_xfer) || (mismatch && state == S_TX);
        fin         = !id_valid && !abort && last &&
                      (((state == S_TX) && tx_ready) || ((state == S_RX) && rx_valid));
        irq_set     = id_valid || (|err_set) || fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            idx   <= '0;
            dtreq <= 1'b0;
            done  <= 1'b0;
            irq   <= 1'b0;
            err   <= '0;
        end else begin
            irq <= (irq && !rst_int) || irq_set;
            err <= (err & ~{3{rst_err}}) | err_set;
            if (id_valid) begin
                state <= S_WAIT;
                dtreq <= 1'b1;
                done  <= 1'b0;
                idx   <= '0;
            end else if (abort) begin
                state <= S_IDLE;
            end else begin
                case (state)
                    S_WAIT: begin
                        if (timeout_hit) begin
                            dtreq <= 1'b0;
                            state <= S_IDLE;
                        end else if (ack) begin
                            dtreq <= 1'b0;
                            idx   <= '0;
                            if (!dir_tx)
                                state <= S_RX;
                            else if (expired)
                                state <= S_IDLE;
                            else
                                state <= S_TX;
                        end
                    end
                    S_TX: begin
                        if (tx_ready) begin
                            if (last) begin
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    S_RX: begin
                        if (rx_valid) begin
                            if (last) begin
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/lin_slave_frame_ctrl.sv
module lin_slave_frame_ctrl
    import lsf_pkg::*;
#(
    parameter int RSP_WINDOW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [ID_W-1:0]  id_value,
    input  logic             rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic             bus_active,
    input  logic             lin_frame_err,
    input  logic             tx_mismatch,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    input  logic [3:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic             irq
);

    logic             dtreq, done, expired, fw_access;
    logic             ctrl_wr, ack, rst_int, rst_err, buf_fw_we;
    logic             dir_q;
    logic [3:0]       len_q;
    logic [ID_W-1:0]  id_q;
    logic [IDX_W-1:0] idx, core_addr;
    logic             core_we;
    logic [DATA_W-1:0] buf_rd_a;
    err_flags_t       err;

    assign fw_access = !bus_active && (dtreq || done);
    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign ack       = ctrl_wr && reg_wdata[C_ACK] && dtreq;
    assign rst_int   = ctrl_wr && reg_wdata[C_RINT];
    assign rst_err   = ctrl_wr && reg_wdata[C_RERR];
    assign buf_fw_we = reg_wr && !reg_addr[3] && fw_access;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b0;
            len_q <= '0;
            id_q  <= '0;
        end else begin
            if (ctrl_wr)
                dir_q <= reg_wdata[C_DIR];
            if (reg_wr && reg_addr == A_LEN)
                len_q <= reg_wdata[3:0];
            if (id_valid)
                id_q <= id_value;
            else if (reg_wr && reg_addr == A_ID && fw_access)
                id_q <= reg_wdata[ID_W-1:0];
        end
    end

    lsf_window #(.WINDOW(RSP_WINDOW)) i_window (
        .clk     (clk),
        .rst     (rst),
        .restart (id_valid),
        .expired (expired)
    );

    lsf_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .rx_valid  (rx_valid),
        .tx_ready  (tx_ready),
        .frame_err (lin_frame_err),
        .mismatch  (tx_mismatch),
        .ack       (ack),
        .dir_tx    (reg_wdata[C_DIR]),
        .expired   (expired),
        .len_eff   (eff_len(len_q)),
        .rst_int   (rst_int),
        .rst_err   (rst_err),
        .idx       (idx),
        .dtreq     (dtreq),
        .done      (done),
        .irq       (irq),
        .err       (err),
        .core_we   (core_we),
        .core_addr (core_addr),
        .tx_valid  (tx_valid)
    );

    lsf_buffer i_buffer (
        .clk        (clk),
        .rst        (rst),
        .fw_we      (buf_fw_we),
        .fw_addr    (reg_addr[IDX_W-1:0]),
        .fw_wdata   (reg_wdata),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (rx_byte),
        .rd_addr_a  (reg_addr[IDX_W-1:0]),
        .rd_addr_b  (idx),
        .rd_a       (buf_rd_a),
        .rd_b       (tx_byte)
    );

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[3]) begin
            if (fw_access)
                reg_rdata = buf_rd_a;
        end else begin
            case (reg_addr)
                A_STAT:  reg_rdata = {bus_active, 2'b00, dtreq, 1'b0, |err, 1'b0, done};
                A_CTRL:  reg_rdata = {2'b00, dir_q, 5'b00000};
                A_ERR:   reg_rdata = {5'b00000, err};
                A_LEN:   reg_rdata = {4'b0000, len_q};
                A_ID:    reg_rdata = fw_access ? {2'b00, id_q} : '0;
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsf_checker.sv
module lsf_checker (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       id_valid,
    input logic       rx_valid,
    input logic       tx_ready,
    input logic       lin_frame_err,
    input logic       tx_mismatch,
    input logic       tx_valid,
    input logic [3:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       bus_active,
    input logic       dtreq,
    input logic       done
);

    // R1: interrupt only follows a lower-layer event
    a_r1_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(id_valid || rx_valid || tx_ready || lin_frame_err || tx_mismatch));

    // R1: interrupt reset write with no concurrent event drops irq
    a_r1_irq_reset: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h9 && reg_wdata[3] && !id_valid && !rx_valid &&
         !tx_ready && !lin_frame_err && !tx_mismatch) |=> !irq);

    // R4: fenced reads return zero
    a_r4_fenced_read: assert property (@(posedge clk) disable iff (rst)
        ((!reg_addr[3] || reg_addr == 4'hC) && (bus_active || !(dtreq || done)))
        |-> reg_rdata == 8'h00);

    // R5: nothing is offered while a request is pending
    a_r5_no_tx_on_req: assert property (@(posedge clk) disable iff (rst)
        dtreq |-> !tx_valid);

    // R3: done and a pending request never coexist
    a_r3_done_vs_req: assert property (@(posedge clk) disable iff (rst)
        done |-> !dtreq);

endmodule

bind lin_slave_frame_ctrl lsf_checker i_chk (.*);

// File: tb/test_lin_slave_frame_ctrl.sv
module test_lin_slave_frame_ctrl;

    localparam int WIN = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [5:0] id_value = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       bus_active = 1'b0;
    logic       lin_frame_err = 1'b0;
    logic       tx_mismatch = 1'b0;
    logic       tx_ready = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    // stimulus {length written, bytes expected}
    localparam logic [7:0] LEN_VEC [0:5] = '{8'h08, 8'h11, 8'h33, 8'h88, 8'h98, 8'hF8};

    always #10 clk = ~clk;

    lin_slave_frame_ctrl #(.RSP_WINDOW(WIN)) i_lin_slave_frame_ctrl (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_id(input logic [5:0] v);
        @(negedge clk);
        id_valid = 1'b1; id_value = v;
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // serve the transmitter for up to max_cyc cycles, count offered bytes
    task automatic drain_tx(input int max_cyc, input logic [7:0] base, input string req,
                            output int cnt);
        cnt = 0;
        for (int c = 0; c < max_cyc; c++) begin
            @(negedge clk);
            tx_ready = 1'b0;
            if (tx_valid) begin
                check(req, tx_byte, base + 8'(cnt * 37));
                cnt++;
                tx_ready = 1'b1;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int cnt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(4'h8, d); check("R2 status after reset", d, 8'h00);
        check("R5 tx idle after reset", {7'b0, tx_valid}, 8'h00);
        wr(4'h2, 8'h5A);
        rd(4'h2, d); check("R4 buffer fenced with no request", d, 8'h00);

        // identifier event
        send_id(6'h2A);
        check("R1 irq on identifier", {7'b0, irq}, 8'h01);
        rd(4'h8, d); check("R2 R3 status request pending", d, 8'h10);
        rd(4'hC, d); check("R3 identifier latched", d, 8'h2A);
        bus_active = 1'b1;
        rd(4'h8, d); check("R2 active bit", d, 8'h90);
        rd(4'hC, d); check("R4 identifier fenced while active", d, 8'h00);
        wr(4'h1, 8'h77);
        bus_active = 1'b0;
        rd(4'h1, d); check("R4 write ignored while active", d, 8'h00);
        wr(4'h9, 8'h08);
        check("R1 interrupt reset", {7'b0, irq}, 8'h00);
        rd(4'h9, d); check("R1 self-clearing control bits", d, 8'h00);

        // length table walked by one loop: transmit responses
        foreach (LEN_VEC[i]) begin
            send_id(6'(i + 1));
            wr(4'h9, 8'h08);
            for (int k = 0; k < 8; k++) wr(4'(k), 8'h11 + 8'(k * 37));
            wr(4'hB, {4'h0, LEN_VEC[i][7:4]});
            check("R5 no tx before acknowledge", {7'b0, tx_valid}, 8'h00);
            wr(4'h9, 8'h30);
            drain_tx(12, 8'h11, "R6 transmit byte", cnt);
            check("R7 R6 bytes sent for length", 8'(cnt), {4'h0, LEN_VEC[i][3:0]});
            rd(4'h8, d); check("R6 done after transmit", d, 8'h01);
            check("R6 irq after transmit", {7'b0, irq}, 8'h01);
        end

        // receive response
        send_id(6'h11);
        wr(4'h9, 8'h08);
        wr(4'hB, 8'h03);
        wr(4'h9, 8'h10);
        rd(4'h8, d); check("R5 acknowledge clears request", d, 8'h00);
        send_rx(8'hA1);
        send_rx(8'hB2);
        check("R9 no irq mid receive", {7'b0, irq}, 8'h00);
        send_rx(8'hC3);
        check("R9 irq after receive", {7'b0, irq}, 8'h01);
        rd(4'h8, d); check("R9 done after receive", d, 8'h01);
        rd(4'h0, d); check("R9 byte 0", d, 8'hA1);
        rd(4'h1, d); check("R9 byte 1", d, 8'hB2);
        rd(4'h2, d); check("R9 byte 2", d, 8'hC3);

        // late transmit acknowledge
        send_id(6'h05);
        wr(4'h9, 8'h08);
        repeat (WIN + 8) @(negedge clk);
        wr(4'h9, 8'h30);
        drain_tx(10, 8'h00, "R8 unexpected byte", cnt);
        check("R8 nothing sent after window", 8'(cnt), 8'h00);
        rd(4'h8, d); check("R8 request cleared, no done", d, 8'h00);
        check("R8 no irq", {7'b0, irq}, 8'h00);

        // receive timeout: byte before acknowledge
        send_id(6'h06);
        wr(4'h9, 8'h08);
        send_rx(8'h3C);
        check("R10 irq on timeout", {7'b0, irq}, 8'h01);
        rd(4'hA, d); check("R10 timeout flag", d, 8'h01);
        rd(4'h8, d); check("R10 error set, request cleared", d, 8'h04);
        wr(4'h9, 8'h0C);
        rd(4'hA, d); check("R11 error reset", d, 8'h00);
        send_id(6'h07);
        rd(4'h0, d); check("R10 buffer entry 0 overwritten", d, 8'h3C);

        // mismatch during transmit
        wr(4'h9, 8'h08);
        wr(4'hB, 8'h04);
        wr(4'h9, 8'h30);
        @(negedge clk);
        check("R6 first byte offered", {7'b0, tx_valid}, 8'h01);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0; tx_mismatch = 1'b1;
        @(negedge clk);
        tx_mismatch = 1'b0;
        check("R11 transmit aborted on mismatch", {7'b0, tx_valid}, 8'h00);
        rd(4'hA, d); check("R11 mismatch flag", d, 8'h02);
        rd(4'h8, d); check("R11 no done after abort", d, 8'h04);
        wr(4'h9, 8'h0C);

        // framing error during receive
        send_id(6'h08);
        wr(4'h9, 8'h08);
        wr(4'hB, 8'h02);
        wr(4'h9, 8'h10);
        send_rx(8'h55);
        @(negedge clk);
        lin_frame_err = 1'b1;
        @(negedge clk);
        lin_frame_err = 1'b0;
        check("R11 irq on framing error", {7'b0, irq}, 8'h01);
        wr(4'h9, 8'h08);
        send_rx(8'h66);
        rd(4'hA, d); check("R11 framing flag", d, 8'h04);
        rd(4'h8, d); check("R11 receive aborted, no done", d, 8'h04);
        check("R11 no irq after aborted byte", {7'b0, irq}, 8'h00);

        finish_run();
    end

endmodule